// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

The walker serves one drive channel's DMA engine. Software places a table of 8-byte descriptors in memory. Each descriptor names a memory region and its byte count, and one flag marks the end of the table. The walker reads descriptors one at a time through a simple read-request port. It then issues burst requests (address, length, direction, buffer index) that move bytes between the sector buffer and those regions. Each request it accepts asks for a given number of buffer bytes.

A request ends in one of two ways. `done_o` pulses when every requested byte has been moved. `exhausted_o` pulses when the table ran out first. The table runs out either because the end flag was seen or because the table pointer has moved a full page past the table base, which guards against a table that has no end flag. Bytes left in a descriptor after a request completes stay pending and are used by the next request. `restart_i` rewinds the table pointer to a newly latched base. `start_i` discards any pending descriptor state.

Top module: `prd_walker`

## Requirements
- R1: After reset `busy_o`, `fetch_req_o`, `burst_req_o`, `done_o` and `exhausted_o` are all low.
- R2: A descriptor fetch reads 8 bytes at the table pointer. In `fetch_data_i`, bits [31:0] are the region address and bits [63:32] are the size/flags word. The pointer advances by 8 on each accepted fetch.
- R3: The descriptor byte count is size word bits [15:0] with bit 0 cleared. Size bits [30:16] are ignored, and a resulting count of zero means 65536 bytes.
- R4: Size word bit 31 marks the final descriptor. No fetch follows it until `start_i` clears the flag.
- R5: Each burst length is the smaller of the remaining requested bytes and the remaining descriptor bytes. After each acknowledged burst, the region address and buffer index advance by that length. Descriptor bytes left over when a request completes are used first by the next request.
- R6: `burst_write_o` equals the `req_write_i` value latched with the request. 1 means buffer to memory and 0 means memory to buffer.
- R7: `done_o` pulses for one cycle once the requested byte count has been moved. A zero-byte request completes with no fetch and no burst.
- R8: `exhausted_o` pulses when requested bytes remain, the current descriptor is empty, and the table has ended. No bytes beyond the table capacity are moved.
- R9: No descriptor fetch is issued once (pointer − base) ≥ `PAGE_BYTES`, even if no end flag has been seen.
- R10: `restart_i` latches `base_i` (low two bits cleared) as the base and sets the pointer to it. It aborts any walk but keeps pending descriptor bytes.
- R11: `start_i` clears the pending descriptor length, the end flag and the region address, and aborts any walk. It leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_i | input | 32 | Table base, latched on restart |
| restart_i | input | 1 | Rewind pointer to base, abort walk |
| start_i | input | 1 | Clear pending descriptor state, abort walk |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_len_i | input | REQ_W | Buffer bytes to move |
| req_write_i | input | 1 | 1 = buffer to memory, 0 = memory to buffer |
| busy_o | output | 1 | Walk in progress |
| fetch_req_o | output | 1 | Descriptor read request |
| fetch_addr_o | output | 32 | Descriptor address |
| fetch_ack_i | input | 1 | Descriptor read data valid |
| fetch_data_i | input | 64 | Descriptor: [31:0] address, [63:32] size/flags |
| burst_req_o | output | 1 | Burst request |
| burst_addr_o | output | 32 | Region address of burst |
| burst_len_o | output | 17 | Burst byte count |
| burst_write_o | output | 1 | Burst direction |
| burst_idx_o | output | REQ_W | Buffer offset of burst |
| burst_ack_i | input | 1 | Burst accepted |
| done_o | output | 1 | Request complete pulse |
| exhausted_o | output | 1 | Table ended early pulse |

## Verification
The bench sweeps three tables with a small page size.

- The first table has four short entries ending in an end flag. Its request lengths range from zero past the table capacity. This separates a clean finish, a finish exactly at capacity, and exhaustion on the end flag.
- The second table has no end flag and junk in the upper size bits. It exposes the page fail-safe and the masking, and it runs with acknowledge wait states.
- The third table has a single zero-count entry. It tells the 65536-byte rule apart from a plain zero.

Chained requests show leftover-byte carry-over. Restart-only and start-only sequences distinguish pointer rewind from clearing the descriptor state.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam int unsigned DLEN_W     = 17;
  localparam int unsigned DESC_BYTES = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_MOVE
  } walk_state_e;

  typedef struct packed {
    logic [31:0]       addr;
    logic [DLEN_W-1:0] len;
    logic              last;
  } desc_t;
endpackage

// File: rtl/prd_decode.sv
module prd_decode
  import prd_pkg::*;
(
  input  logic [63:0] raw_i,
  output desc_t       desc_o
);
  logic [15:0] cnt;

  always_comb begin
    cnt         = raw_i[47:32] & 16'hFFFE;
    desc_o.addr = raw_i[31:0];
    desc_o.last = raw_i[63];
    // zero count encodes a full 64 KiB region
    desc_o.len  = (cnt == 16'd0) ? 17'h10000 : {1'b0, cnt};
  end
endmodule

// File: rtl/prd_chunk.sv
module prd_chunk
  import prd_pkg::*;
#(
  parameter int unsigned REQ_W = 20
) (
  input  logic [REQ_W-1:0]  buf_rem_i,
  input  logic [DLEN_W-1:0] desc_rem_i,
  output logic [DLEN_W-1:0] chunk_o
);
  logic [REQ_W-1:0] desc_ext;
  logic [REQ_W-1:0] pick;

  always_comb begin
    desc_ext = REQ_W'(desc_rem_i);
    pick     = (buf_rem_i < desc_ext) ? buf_rem_i : desc_ext;
    chunk_o  = pick[DLEN_W-1:0];
  end
endmodule

// File: rtl/prd_ptr.sv
module prd_ptr
  import prd_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 4096
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reload_i,
  input  logic [31:0] base_i,
  input  logic        step_i,
  output logic [31:0] ptr_o,
  output logic [31:0] base_o,
  output logic        open_o
);
  logic [31:0] ptr_q, base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      base_q <= '0;
    end else if (reload_i) begin
      ptr_q  <= {base_i[31:2], 2'b00};
      base_q <= {base_i[31:2], 2'b00};
    end else if (step_i) begin
      ptr_q  <= ptr_q + 32'(DESC_BYTES);
    end
  end

  assign ptr_o  = ptr_q;
  assign base_o = base_q;
  assign open_o = (ptr_q - base_q) < 32'(PAGE_BYTES);
endmodule

// File: rtl/prd_walker.sv
module prd_walker
  import prd_pkg::*;
#(
  parameter int unsigned REQ_W      = 20,
  parameter int unsigned PAGE_BYTES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       base_i,
  input  logic              restart_i,
  input  logic              start_i,
  input  logic              req_valid_i,
  input  logic [REQ_W-1:0]  req_len_i,
  input  logic              req_write_i,
  output logic              busy_o,
  output logic              fetch_req_o,
  output logic [31:0]       fetch_addr_o,
  input  logic              fetch_ack_i,
  input  logic [63:0]       fetch_data_i,
  output logic              burst_req_o,
  output logic [31:0]       burst_addr_o,
  output logic [16:0]       burst_len_o,
  output logic              burst_write_o,
  output logic [REQ_W-1:0]  burst_idx_o,
  input  logic              burst_ack_i,
  output logic              done_o,
  output logic              exhausted_o
);
  walk_state_e       state_q;
  logic [REQ_W-1:0]  buf_rem_q, idx_q;
  logic [DLEN_W-1:0] desc_rem_q, chunk;
  logic [31:0]       region_q, ptr, base;
  logic              last_q, dir_q, open, abort, ptr_step;
  desc_t             desc;

  assign abort    = start_i | restart_i;
  assign ptr_step = (state_q == ST_FETCH) & fetch_ack_i & ~abort;

  prd_ptr #(.PAGE_BYTES(PAGE_BYTES)) i_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .reload_i(restart_i),
    .base_i  (base_i),
    .step_i  (ptr_step),
    .ptr_o   (ptr),
    .base_o  (base),
    .open_o  (open)
  );

  prd_decode i_dec (
    .raw_i (fetch_data_i),
    .desc_o(desc)
  );

  prd_chunk #(.REQ_W(REQ_W)) i_chunk (
    .buf_rem_i (buf_rem_q),
    .desc_rem_i(desc_rem_q),
    .chunk_o   (chunk)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      buf_rem_q  <= '0;
      idx_q      <= '0;
      desc_rem_q <= '0;
      region_q   <= '0;
      last_q     <= 1'b0;
      dir_q      <= 1'b0;
    end else if (abort) begin
      state_q <= ST_IDLE;
      if (start_i) begin
        desc_rem_q <= '0;
        last_q     <= 1'b0;
        region_q   <= '0;
      end
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          buf_rem_q <= req_len_i;
          idx_q     <= '0;
          dir_q     <= req_write_i;
          state_q   <= ST_CHECK;
        end
        ST_CHECK: begin
          if (buf_rem_q == '0)            state_q <= ST_IDLE;
          else if (desc_rem_q != '0)      state_q <= ST_MOVE;
          else if (last_q || !open)       state_q <= ST_IDLE;
          else                            state_q <= ST_FETCH;
        end
        ST_FETCH: if (fetch_ack_i) begin
          region_q   <= desc.addr;
          desc_rem_q <= desc.len;
          last_q     <= desc.last;
          state_q    <= ST_CHECK;
        end
        ST_MOVE: if (burst_ack_i) begin
          region_q   <= region_q + 32'(chunk);
          desc_rem_q <= desc_rem_q - chunk;
          buf_rem_q  <= buf_rem_q - REQ_W'(chunk);
          idx_q      <= idx_q + REQ_W'(chunk);
          state_q    <= ST_CHECK;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign fetch_req_o   = (state_q == ST_FETCH);
  assign fetch_addr_o  = ptr;
  assign burst_req_o   = (state_q == ST_MOVE);
  assign burst_addr_o  = region_q;
  assign burst_len_o   = chunk;
  assign burst_write_o = dir_q;
  assign burst_idx_o   = idx_q;
  assign done_o        = (state_q == ST_CHECK) && (buf_rem_q == '0);
  assign exhausted_o   = (state_q == ST_CHECK) && (buf_rem_q != '0) &&
                         (desc_rem_q == '0) && (last_q || !open);

  p_fetch_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && !fetch_ack_i && !abort |=> fetch_req_o && $stable(fetch_addr_o));

  p_ptr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && fetch_ack_i && !abort |=> fetch_addr_o == $past(fetch_addr_o) + 32'd8);

  p_no_fetch_after_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> !last_q);

  p_page_guard_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> (fetch_addr_o - base) < 32'(PAGE_BYTES));

  p_chunk_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_req_o |-> burst_len_o != '0 && REQ_W'(burst_len_o) <= buf_rem_q);

  p_dir_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_req_o && $past(busy_o) |-> $stable(burst_write_o));

  p_outcome_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exhausted_o |=> !busy_o && !done_o);
endmodule

// File: tb/test_prd_walker.sv
module test_prd_walker;
  localparam int unsigned REQ_W = 20;
  localparam int unsigned PAGE  = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] base_i = '0;
  logic restart_i = 0, start_i = 0, req_valid_i = 0, req_write_i = 0;
  logic [REQ_W-1:0] req_len_i = '0;
  logic fetch_ack_i = 0, burst_ack_i = 0;
  logic [63:0] fetch_data_i = '0;
  logic busy_o, fetch_req_o, burst_req_o, burst_write_o, done_o, exhausted_o;
  logic [31:0] fetch_addr_o, burst_addr_o;
  logic [16:0] burst_len_o;
  logic [REQ_W-1:0] burst_idx_o;

  always #10 clk = ~clk;

  prd_walker #(.REQ_W(REQ_W), .PAGE_BYTES(PAGE)) i_prd_walker (
    .clk_i(clk), .rst_ni(rst_n), .base_i(base_i), .restart_i(restart_i),
    .start_i(start_i), .req_valid_i(req_valid_i), .req_len_i(req_len_i),
    .req_write_i(req_write_i), .busy_o(busy_o), .fetch_req_o(fetch_req_o),
    .fetch_addr_o(fetch_addr_o), .fetch_ack_i(fetch_ack_i),
    .fetch_data_i(fetch_data_i), .burst_req_o(burst_req_o),
    .burst_addr_o(burst_addr_o), .burst_len_o(burst_len_o),
    .burst_write_o(burst_write_o), .burst_idx_o(burst_idx_o),
    .burst_ack_i(burst_ack_i), .done_o(done_o), .exhausted_o(exhausted_o));

  int n_tests = 0, n_fail = 0;
  int mode = 0, wait_n = 0;
  logic [31:0] m_ptr, m_base, m_region;
  longint m_rem, m_buf, m_idx;
  bit m_last, m_dir;
  // results of last run
  longint r_moved;
  bit r_done, r_exh;
  int r_first, r_nfetch;
  logic [31:0] r_first_fetch;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [63:0] desc_of(input int md, input int idx);
    logic [31:0] a, s;
    a = 32'h1000_0000 + 32'(md) * 32'h0010_0000 + 32'(idx) * 32'h100;
    case (md)
      0: begin
        case (idx)
          0: s = 32'd6;
          1: s = 32'd11;                 // odd: bit 0 dropped
          2: s = 32'h0012_0010;          // junk above bit 15
          default: s = 32'h8000_0008;    // last
        endcase
      end
      1: s = 32'h7F00_0005;              // count 4, never last
      default: s = 32'h8000_0001;        // count 0 -> 65536, last
    endcase
    return {s, a};
  endfunction

  task automatic do_restart(input logic [31:0] b);
    @(negedge clk); base_i = b; restart_i = 1;
    @(negedge clk); restart_i = 0;
    m_base = {b[31:2], 2'b00}; m_ptr = m_base;
  endtask

  task automatic do_start();
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    m_rem = 0; m_last = 0; m_region = '0;
  endtask

  task automatic run(input longint len, input bit dir);
    longint exp, cnt;
    logic [63:0] d;
    int wc;
    bit fin;
    r_moved = 0; r_done = 0; r_exh = 0; r_first = 0; r_nfetch = 0; r_first_fetch = '0;
    wc = 0; fin = 0;
    @(negedge clk);
    req_valid_i = 1; req_len_i = REQ_W'(len); req_write_i = dir;
    m_buf = len; m_idx = 0; m_dir = dir;
    @(negedge clk);
    req_valid_i = 0;
    for (int c = 0; c < 600 && !fin; c++) begin
      fetch_ack_i = 0; burst_ack_i = 0;
      if (fetch_req_o) begin
        if (r_first == 0) r_first = 1;
        if (wc < wait_n) wc++;
        else begin
          wc = 0;
          if (r_nfetch == 0) r_first_fetch = fetch_addr_o;
          r_nfetch++;
          chk(fetch_addr_o == m_ptr, "R2 fetch address", longint'(fetch_addr_o), longint'(m_ptr));
          chk(!m_last, "R4 fetch after last", 1, 0);
          chk((m_ptr - m_base) < PAGE, "R9 fetch beyond page", longint'(m_ptr - m_base), PAGE);
          d = desc_of(mode, int'((m_ptr - m_base) >> 3));
          fetch_data_i = d;
          fetch_ack_i = 1;
          cnt = longint'(d[47:32] & 16'hFFFE);
          m_rem = (cnt == 0) ? 65536 : cnt;
          m_region = d[31:0];
          m_last = d[63];
          m_ptr = m_ptr + 8;
        end
      end else if (burst_req_o) begin
        if (r_first == 0) r_first = 2;
        if (wc < wait_n) wc++;
        else begin
          wc = 0;
          exp = (m_buf < m_rem) ? m_buf : m_rem;
          chk(longint'(burst_len_o) == exp, "R5 burst length", longint'(burst_len_o), exp);
          chk(burst_addr_o == m_region, "R5 burst address", longint'(burst_addr_o), longint'(m_region));
          chk(longint'(burst_idx_o) == m_idx, "R5 buffer index", longint'(burst_idx_o), m_idx);
          chk(burst_write_o == m_dir, "R6 direction", longint'(burst_write_o), longint'(m_dir));
          burst_ack_i = 1;
          m_region = m_region + 32'(exp);
          m_rem -= exp; m_buf -= exp; m_idx += exp; r_moved += exp;
        end
      end else if (done_o) begin
        r_done = 1; fin = 1;
        chk(m_buf == 0, "R7 done with bytes left", m_buf, 0);
      end else if (exhausted_o) begin
        r_exh = 1; fin = 1;
        chk(m_buf != 0 && m_rem == 0 && (m_last || (m_ptr - m_base) >= PAGE),
            "R8 premature exhaustion", m_buf, 0);
      end
      if (!fin) @(negedge clk);
    end
    fetch_ack_i = 0; burst_ack_i = 0;
    if (!fin) chk(0, "R7 request never ended", 0, 1);
  endtask

  initial begin
    #4_000_000;
    n_fail++; n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_ptr = '0; m_base = '0; m_region = '0; m_rem = 0; m_buf = 0; m_idx = 0;
    m_last = 0; m_dir = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy_o, fetch_req_o, burst_req_o, done_o, exhausted_o} == 5'b0,
        "R1 reset outputs", longint'({busy_o, fetch_req_o, burst_req_o, done_o, exhausted_o}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy_o, "R1 idle after reset", longint'(busy_o), 0);

    // Table 0: capacity 6+10+16+8 = 40, end flag on entry 3
    mode = 0;
    for (int len = 0; len <= 44; len++) begin
      do_start(); do_restart(32'h0000_4003);
      run(longint'(len), len[0]);
      chk(r_moved == ((len < 40) ? len : 40), "R8 bytes moved vs capacity", r_moved, (len < 40) ? len : 40);
      chk(r_done == (len <= 40), "R7 outcome", longint'(r_done), longint'(len <= 40));
      if (len == 0) chk(r_nfetch == 0 && r_first == 0, "R7 zero request touches nothing", r_first, 0);
      if (len > 40) chk(r_nfetch == 4, "R4 stop at last entry", r_nfetch, 4);
      if (len == 16) chk(r_nfetch == 2, "R3 odd count masked", r_nfetch, 2);
    end

    // Table 1: no end flag, page fail-safe at 8 entries, wait states
    mode = 1; wait_n = 1;
    for (int len = 28; len <= 36; len++) begin
      do_start(); do_restart(32'h0002_0040);
      run(longint'(len), 1'b1);
      chk(r_moved == ((len < 32) ? len : 32), "R9 capacity bounded by page", r_moved, (len < 32) ? len : 32);
      chk(r_exh == (len > 32), "R9 exhaustion without end flag", longint'(r_exh), longint'(len > 32));
      if (len > 32) chk(r_nfetch == 8, "R9 fetch count", r_nfetch, 8);
    end
    wait_n = 0;

    // Table 2: zero count means 65536
    mode = 2;
    do_start(); do_restart(32'h0003_0000);
    run(70000, 1'b0);
    chk(r_moved == 65536 && r_exh, "R3 zero count is 64 KiB", r_moved, 65536);
    do_start(); do_restart(32'h0003_0000);
    run(100, 1'b1);
    chk(r_moved == 100 && r_done, "R3 partial of 64 KiB entry", r_moved, 100);

    // Carry-over, restart and start on table 0
    mode = 0;
    do_start(); do_restart(32'h0000_5000);
    run(5, 1'b0);
    chk(r_done && r_moved == 5, "R5 first partial request", r_moved, 5);
    run(10, 1'b1);
    chk(r_first == 2, "R5 leftover used before fetch", r_first, 2);
    chk(r_done && r_moved == 10, "R5 second request", r_moved, 10);
    do_restart(32'h0000_5000);
    run(6, 1'b0);
    chk(r_first == 2, "R10 pending bytes kept over restart", r_first, 2);
    chk(r_first_fetch == 32'h0000_5000, "R10 fetch rewound to base",
        longint'(r_first_fetch), 32'h5000);
    chk(r_done && r_moved == 6, "R10 request after restart", r_moved, 6);
    do_start();
    run(3, 1'b1);
    chk(r_first == 1, "R11 start drops pending bytes", r_first, 1);
    chk(r_first_fetch == 32'h0000_5008, "R11 pointer kept over start",
        longint'(r_first_fetch), 32'h5008);
    chk(r_done && r_moved == 3, "R11 request after start", r_moved, 3);

    // start while mid-walk aborts the request
    do_start(); do_restart(32'h0000_6000);
    @(negedge clk); req_valid_i = 1; req_len_i = 20'd8; req_write_i = 1;
    @(negedge clk); req_valid_i = 0;
    @(negedge clk);
    chk(fetch_req_o == 1, "R2 fetch issued", longint'(fetch_req_o), 1);
    start_i = 1; m_rem = 0; m_last = 0; m_region = '0;
    @(negedge clk); start_i = 0;
    chk(!busy_o && !fetch_req_o, "R11 start aborts walk", longint'(busy_o), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule